// File: doc/BRIEF.md
# Byte-Lane Memory Access Sequencer

This block sits between a load/store requester and a 16-bit wide memory built from two 8-bit banks. The requester presents a byte or word operation at any byte address in a 20-bit space. The sequencer turns it into one or two bus cycles. It puts the bytes on the correct lanes, drives the two bank enables and collects read bytes back into a right-justified result.

Bytes at even addresses use data bits 7:0, and bytes at odd addresses use bits 15:8. A bank enable (`bus_bhe_n`, active low) together with address bit 0 (`bus_addr[0]`) selects the even byte, the odd byte, or both. A word at an even address needs a single cycle. A word at an odd address is split into two byte cycles. The first moves the low byte at A on the high lane. The second moves the high byte at A+1 on the low lane. The split changes only the latency seen by the requester.

A request is taken when `req_valid` and `req_ready` are both high at a clock edge. Each bus cycle lasts until `bus_rdy` is sampled high. `done` pulses once when the whole request has finished.

Top module: `byte_lane_seq`

## Requirements
- R1: After reset `req_ready` is 1, and `bus_cyc` and `done` are 0.
- R2: A request is accepted only on an edge where `req_valid` and `req_ready` are both 1. `bus_cyc` rises in the next cycle with `bus_addr` equal to the request address. `req_ready` equals the inverse of `bus_cyc`.
- R3: A word at an even address uses one cycle with `bus_bhe_n`=0 and `bus_addr[0]`=0. Write data appears unchanged on `bus_wdata`, and the read result equals `bus_rdata`.
- R4: A byte at an even address uses `bus_bhe_n`=1 and `bus_addr[0]`=0. The write byte is on bits 7:0 with bits 15:8 zero. The read result is `{8'h00, bus_rdata[7:0]}`.
- R5: A byte at an odd address uses `bus_bhe_n`=0 and `bus_addr[0]`=1. The write byte is on bits 15:8 with bits 7:0 zero. The read result is `{8'h00, bus_rdata[15:8]}`.
- R6: A word at an odd address A takes two cycles. The first cycle is at A with `bus_bhe_n`=0 and write data `{wdata[7:0],8'h00}`. The second is at A+1 with `bus_bhe_n`=1 and write data `{8'h00,wdata[15:8]}`. The read result is `{second-cycle bus_rdata[7:0], first-cycle bus_rdata[15:8]}`.
- R7: The address A+1 of a split word wraps modulo 2^20, so a word at 0xFFFFF continues at 0x00000.
- R8: While `bus_cyc` is 1 and `bus_rdy` is 0, address, enable, write strobe and write data hold their values.
- R9: `done` is a one-cycle pulse in the cycle after the edge that samples `bus_rdy` high on the last bus cycle of a request. For reads, `rdata` holds the result while `done` is high.
- R10: During a bus cycle, `bus_bhe_n`=1 together with `bus_addr[0]`=1 never occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_word | input | 1 | 1 = 16-bit operand, 0 = byte |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Store data, right-justified for bytes |
| req_ready | output | 1 | Sequencer idle, can take a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Load result, right-justified, valid with done |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | 20 | Bus byte address, bit 0 is the even/odd select |
| bus_bhe_n | output | 1 | High-bank (bits 15:8) enable, active low |
| bus_wdata | output | 16 | Write data on lanes |
| bus_rdata | input | 16 | Read data from both banks |
| bus_rdy | input | 1 | Ends the current bus cycle when high |

## Verification
The hardest case to reach is a misaligned word at the very top of the address space, with the bus stalling inside either half. The stall must hold the first half stable, the step to the second half must wrap to zero, and the reassembly must still take the byte saved from the first half. A new request also has to be waiting in the same cycle as the `done` pulse. The stimulus places directed odd words at 0xFFFFF and its neighbours. It then runs a long back-to-back stream with pseudo-random ready gaps and addresses drawn near both ends of the space, so every split meets stalls at different points. Read data comes from a deterministic byte-per-address function, so the bench knows the expected value for every lane.

// File: rtl/byte_lane_seq.sv
module byte_lane_seq #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_word,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic [15:0]   rdata,
  output logic          bus_cyc,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic          bus_bhe_n,
  output logic [15:0]   bus_wdata,
  input  logic [15:0]   bus_rdata,
  input  logic          bus_rdy
);

  logic          busy, second, wr, word;
  logic [AW-1:0] addr;
  logic [15:0]   wd;
  logic [7:0]    lo_byte;
  logic          both, split_first;
  logic [15:0]   result;

  assign both        = word & ~addr[0];
  assign split_first = busy & ~second & word & addr[0];

  assign req_ready = ~busy;
  assign bus_cyc   = busy;
  assign bus_we    = busy & wr;
  assign bus_addr  = second ? addr + AW'(1) : addr;
  assign bus_bhe_n = ~(busy & (both | bus_addr[0]));

  always_comb begin
    if (!busy)           bus_wdata = 16'h0000;
    else if (both)       bus_wdata = wd;
    else if (second)     bus_wdata = {8'h00, wd[15:8]};
    else if (addr[0])    bus_wdata = {wd[7:0], 8'h00};
    else                 bus_wdata = {8'h00, wd[7:0]};
  end

  always_comb begin
    if (second)          result = {bus_rdata[7:0], lo_byte};
    else if (both)       result = bus_rdata;
    else if (addr[0])    result = {8'h00, bus_rdata[15:8]};
    else                 result = {8'h00, bus_rdata[7:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      second  <= 1'b0;
      wr      <= 1'b0;
      word    <= 1'b0;
      addr    <= '0;
      wd      <= 16'h0000;
      lo_byte <= 8'h00;
      done    <= 1'b0;
      rdata   <= 16'h0000;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy   <= 1'b1;
          second <= 1'b0;
          wr     <= req_write;
          word   <= req_word;
          addr   <= req_addr;
          wd     <= req_wdata;
        end
      end else if (bus_rdy) begin
        if (split_first) begin
          second  <= 1'b1;
          lo_byte <= bus_rdata[15:8];
        end else begin
          busy   <= 1'b0;
          second <= 1'b0;
          done   <= 1'b1;
          if (!wr) rdata <= result;
        end
      end
    end
  end

endmodule

module byte_lane_seq_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic          bus_cyc,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          bus_bhe_n,
  input logic [15:0]   bus_wdata,
  input logic          bus_rdy,
  input logic          split_first,
  input logic          second
);

  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> bus_cyc);

  a_r7_next_half: assert property (@(posedge clk) disable iff (!rst_n)
    split_first && bus_rdy |=> bus_cyc && second && bus_bhe_n && !bus_addr[0]
      && bus_addr == AW'($past(bus_addr) + 1'b1));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc && !bus_rdy |=> bus_cyc && $stable(bus_addr) && $stable(bus_bhe_n)
      && $stable(bus_wdata) && $stable(bus_we));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bus_cyc && bus_rdy));

  a_r10_lane_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> !(bus_bhe_n && bus_addr[0]));

endmodule

bind byte_lane_seq byte_lane_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .bus_cyc(bus_cyc), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_bhe_n(bus_bhe_n), .bus_wdata(bus_wdata), .bus_rdy(bus_rdy),
  .split_first(split_first), .second(second)
);

// File: tb/byte_lane_seq_test.sv
`timescale 1ns/1ps
module byte_lane_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_write = 0, req_word = 0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, done, bus_cyc, bus_we, bus_bhe_n;
  logic [15:0] rdata, bus_wdata;
  logic [19:0] bus_addr;
  logic [15:0] bus_rdata = 16'hDEAD;
  logic bus_rdy = 1'b1;

  byte_lane_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .done(done), .rdata(rdata), .bus_cyc(bus_cyc),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_bhe_n(bus_bhe_n),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy)
  );

  typedef struct {
    logic [19:0] a;
    logic        bhe_n;
    logic [15:0] wd;
    logic        we;
    int          rq;
  } cyc_t;

  int n_run = 0, n_fail = 0;
  cyc_t q[$];
  logic exp_done = 0, done_we = 0, pend_we = 0, slow = 0;
  logic [15:0] exp_rd = '0, pend_rd = '0;
  int pend_rq = 0, done_rq = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [7:0] mb(logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h5A;
  endfunction

  task automatic chk(int r, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  // Expected bus cycles: R3 even word, R4 even byte, R5 odd byte, R6 odd word, R7 wrapping odd word
  task automatic plan();
    logic [19:0] a = req_addr;
    logic [19:0] a1 = a + 20'd1;
    logic [15:0] w = req_wdata;
    int r;
    if (req_word && !a[0]) begin
      r = 3;
      q.push_back('{a, 1'b0, w, req_write, r});
    end else if (req_word) begin
      r = (a == 20'hFFFFF) ? 7 : 6;
      q.push_back('{a, 1'b0, {w[7:0], 8'h00}, req_write, r});
      q.push_back('{a1, 1'b1, {8'h00, w[15:8]}, req_write, r});
    end else if (a[0]) begin
      r = 5;
      q.push_back('{a, 1'b0, {w[7:0], 8'h00}, req_write, r});
    end else begin
      r = 4;
      q.push_back('{a, 1'b1, {8'h00, w[7:0]}, req_write, r});
    end
    pend_rd = req_word ? {mb(a1), mb(a)} : {8'h00, mb(a)};
    pend_we = req_write;
    pend_rq = r;
  endtask

  task automatic tick();
    @(posedge clk);
    exp_done = 1'b0;
    if (rst_n) begin
      if (q.size() > 0) begin
        if (bus_rdy) begin
          void'(q.pop_front());
          if (q.size() == 0) begin
            exp_done = 1'b1;
            done_we = pend_we;
            done_rq = pend_rq;
            if (!pend_we) exp_rd = pend_rd;
          end
        end
      end else if (req_valid) plan();
    end
    @(negedge clk);
    chk(2, "req_ready", {31'd0, req_ready}, {31'd0, q.size() == 0});
    chk(q.size() > 0 ? q[0].rq : 2, "bus_cyc", {31'd0, bus_cyc}, {31'd0, q.size() > 0});
    if (q.size() > 0) begin
      chk(q[0].rq, "bus_addr", {12'd0, bus_addr}, {12'd0, q[0].a});
      chk(q[0].rq, "bus_bhe_n", {31'd0, bus_bhe_n}, {31'd0, q[0].bhe_n});
      chk(q[0].rq, "bus_we", {31'd0, bus_we}, {31'd0, q[0].we});
      if (q[0].we) chk(q[0].rq, "bus_wdata", {16'd0, bus_wdata}, {16'd0, q[0].wd});
      chk(10, "lane enable", {31'd0, bus_bhe_n & bus_addr[0]}, 32'd0);
    end
    chk(9, "done", {31'd0, done}, {31'd0, exp_done});
    if (exp_done && !done_we) chk(done_rq, "rdata", {16'd0, rdata}, {16'd0, exp_rd});
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    bus_rdy = !slow || (lfsr[2:0] > 3'd2);
    bus_rdata = (q.size() > 0) ? {mb(q[0].a | 20'd1), mb(q[0].a & ~20'd1)} : 16'hDEAD;
  endtask

  task automatic issue(logic w, logic wd_mode, logic [19:0] a, logic [15:0] d);
    logic acc;
    req_write = w; req_word = wd_mode; req_addr = a; req_wdata = d; req_valid = 1'b1;
    do begin
      acc = (q.size() == 0);
      tick();
    end while (!acc);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) tick();
    tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    // R1: idle state after reset
    chk(1, "reset req_ready", {31'd0, req_ready}, 32'd1);
    chk(1, "reset bus_cyc", {31'd0, bus_cyc}, 32'd0);
    chk(1, "reset done", {31'd0, done}, 32'd0);
    tick();

    issue(0, 1, 20'h01234, 16'h0); drain();
    issue(1, 1, 20'h01234, 16'hBEEF); drain();
    issue(0, 0, 20'h05670, 16'h0); drain();
    issue(1, 0, 20'h05670, 16'h00A5); drain();
    issue(0, 0, 20'h05671, 16'h0); drain();
    issue(1, 0, 20'h05671, 16'h003C); drain();
    issue(0, 1, 20'h0ABC3, 16'h0); drain();
    issue(1, 1, 20'h0ABC3, 16'h1357); drain();
    issue(0, 1, 20'hFFFFF, 16'h0); drain();
    issue(1, 1, 20'hFFFFF, 16'hC0DE); drain();
    issue(0, 1, 20'hFFFFE, 16'h0); drain();

    slow = 1'b1;
    issue(0, 1, 20'hFFFFF, 16'h0);
    issue(1, 1, 20'hFFFFF, 16'h2468);
    issue(0, 1, 20'h00001, 16'h0);
    for (int i = 0; i < 400; i++) begin
      logic [19:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr[4] ? {16'hFFFF, lfsr[3:0]} : {16'h0000, lfsr[3:0]};
      if (lfsr[9]) a = {lfsr[15:0], lfsr[11:8]};
      issue(lfsr[5], lfsr[6], a, {lfsr[7:0], lfsr[15:8]});
      if (lfsr[12:11] == 2'b00) drain();
    end
    drain();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule